// File: doc/BRIEF.md
# Five-Channel Compare/Capture Timer Array

This block runs one 16-bit up-counter that acts as a common timebase for five independent channels. Each channel owns a 16-bit compare/capture register, a 7-bit mode register, one input pin and one output pin. The mode bits choose what the channel does. It can latch the timebase when its input pin changes, raise a flag when the timebase reaches its register value, toggle its output pin on that event, or drive an 8-bit pulse-width waveform.

Software reaches the block through a byte-wide register port with a combinational read path and a one-cycle write. All event flags are set by hardware and cleared by software. They are merged with the timebase wrap flag into a single interrupt line. The count rate comes from one of four sources: two clock dividers, a synchronised external count pin, or the raw clock.

Register map (5-bit address): 0x00 control, 0x01 config, 0x02/0x03 counter low/high, 0x08+n mode of channel n, 0x10+n compare low byte of channel n, 0x18+n compare high byte of channel n.

Top module: `pca_array`

## Requirements
- R1: While the run bit (control bit 6) is 1, the counter rises by one on every count tick. While it is 0 the counter holds. Writing address 0x02 or 0x03 loads the low or high counter byte, and such a write takes precedence over a tick in the same cycle.
- R2: Config bits [2:1] select the tick source. 0 gives one tick every PRE_SLOW clocks and 1 gives one every PRE_FAST clocks; both dividers restart from zero whenever the run bit is 0. 2 gives one tick per rising edge of extCount after SYNC_STAGES flops. 3 gives a tick on every clock.
- R3: A tick taken while the counter is 0xFFFF wraps it to 0x0000 and sets the wrap flag (control bit 7). A control write with bit 7 = 0 clears the flag, and a write with bit 7 = 1 leaves it unchanged.
- R4: Control bits [4:0] are the channel flags, with channel n at bit n. A control write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R5: Mode bit 5 enables capture on rising edges of the channel's synchronised input pin, and mode bit 4 enables capture on falling edges. A captured edge copies the counter into the channel register and sets the channel flag. An edge of a direction that is not enabled changes neither.
- R6: With mode bit 6 (compare enable) set, a tick taken while the counter equals the channel register is a match. If mode bit 3 is set, a match sets the channel flag. Without compare enable there is no match.
- R7: With mode bit 2 set, each match toggles the channel output pin. The pin is 0 after reset.
- R8: With mode bits 1 and 6 both set, the output pin is 1 exactly when the counter low byte is greater than or equal to the channel's low compare byte. A tick taken while the counter low byte is 0xFF reloads the low compare byte from the high compare byte.
- R9: Writing a channel's low compare byte clears its compare enable bit, and writing its high compare byte sets it.
- R10: irq is 1 when the wrap flag and config bit 0 are both 1, or when any channel flag is 1 while that channel's mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regAddr |
| extCount | input | 1 | External count pin, asynchronous |
| modPinIn | input | 5 | Channel input pins, asynchronous |
| modPinOut | output | 5 | Channel output pins |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with PRE_SLOW = 6, PRE_FAST = 3 and SYNC_STAGES = 2. Small divider values let a run of a few dozen clocks produce several prescaled ticks, so the floor of edges over divisor can be checked for both dividers in a short window. Keeping the default synchroniser depth leaves the three-clock latency of the pin and count inputs in place, so the capture edges and external count pulses are timed as a user would see them. The five-channel default lets capture, match, toggle and pulse-width modes run side by side on separate channels against one shared counter.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int NUM_MOD = 5;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 5;

  typedef enum logic [1:0] {
    SEL_SLOW = 2'd0,
    SEL_FAST = 2'd1,
    SEL_EXT  = 2'd2,
    SEL_FULL = 2'd3
  } clkSel_t;

  // bit order matches the mode register image (bit 6 down to bit 0)
  typedef struct packed {
    logic cmpEn;
    logic capPos;
    logic capNeg;
    logic matEn;
    logic togEn;
    logic pwmEn;
    logic intEn;
  } pcaMode_t;

  typedef struct packed {
    logic               tick;
    logic               cntLoWr;
    logic               cntHiWr;
    logic [NUM_MOD-1:0] cmpLoWr;
    logic [NUM_MOD-1:0] cmpHiWr;
    logic [NUM_MOD-1:0] flagClr;
    logic               ovfClr;
    logic [BYTE_W-1:0]  wdata;
  } pcaStrobe_t;
endpackage

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
#(
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWe,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [BYTE_W-1:0]              regWdata,
  output logic [BYTE_W-1:0]              regRdata,
  input  logic                           extCount,
  input  logic [CNT_W-1:0]               cntVal,
  input  logic [NUM_MOD-1:0][CNT_W-1:0]  cmpVal,
  input  logic [NUM_MOD-1:0]             modFlag,
  input  logic                           ovfFlag,
  output pcaStrobe_t                     strb,
  output pcaMode_t [NUM_MOD-1:0]         modeReg,
  output logic                           ovfIe,
  output logic                           irq
);
  localparam int DIV_W = $clog2(PRE_SLOW + 1);

  logic [1:0]         grp;
  logic [2:0]         idx;
  logic               ctrlWr, cfgWr, runBit, extRise, tickNow;
  clkSel_t            clkSel;
  logic [DIV_W-1:0]   divCnt, divLimit;
  logic [SYNC_STAGES:0] extSync;
  logic [NUM_MOD-1:0] intEnVec;

  assign grp    = regAddr[4:3];
  assign idx    = regAddr[2:0];
  assign ctrlWr = regWe && grp == 2'd0 && idx == 3'd0;
  assign cfgWr  = regWe && grp == 2'd0 && idx == 3'd1;

  // tick source selection
  assign divLimit = (clkSel == SEL_SLOW) ? DIV_W'(PRE_SLOW - 1) : DIV_W'(PRE_FAST - 1);
  assign extRise  = extSync[SYNC_STAGES-1] & ~extSync[SYNC_STAGES];

  always_comb begin
    unique case (clkSel)
      SEL_SLOW, SEL_FAST: tickNow = runBit && divCnt >= divLimit;
      SEL_EXT:            tickNow = runBit && extRise;
      default:            tickNow = runBit;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      extSync <= '0;
    end else begin
      extSync <= {extSync[SYNC_STAGES-1:0], extCount};
      if (!runBit || clkSel[1] || divCnt >= divLimit) divCnt <= '0;
      else                                             divCnt <= divCnt + 1'b1;
    end
  end

  // configuration and mode registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      ovfIe   <= 1'b0;
      clkSel  <= SEL_SLOW;
      modeReg <= '0;
    end else begin
      if (ctrlWr) runBit <= regWdata[6];
      if (cfgWr) begin
        ovfIe  <= regWdata[0];
        clkSel <= clkSel_t'(regWdata[2:1]);
      end
      for (int i = 0; i < NUM_MOD; i++) begin
        if (regWe && grp == 2'd1 && idx == 3'(i)) modeReg[i] <= pcaMode_t'(regWdata[6:0]);
        else if (strb.cmpLoWr[i])                 modeReg[i].cmpEn <= 1'b0;
        else if (strb.cmpHiWr[i])                 modeReg[i].cmpEn <= 1'b1;
      end
    end
  end

  // strobes toward the datapath
  always_comb begin
    strb         = '0;
    strb.tick    = tickNow;
    strb.wdata   = regWdata;
    strb.cntLoWr = regWe && grp == 2'd0 && idx == 3'd2;
    strb.cntHiWr = regWe && grp == 2'd0 && idx == 3'd3;
    strb.flagClr = ctrlWr ? ~regWdata[NUM_MOD-1:0] : '0;
    strb.ovfClr  = ctrlWr && !regWdata[7];
    for (int i = 0; i < NUM_MOD; i++) begin
      strb.cmpLoWr[i] = regWe && grp == 2'd2 && idx == 3'(i);
      strb.cmpHiWr[i] = regWe && grp == 2'd3 && idx == 3'(i);
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    unique case (grp)
      2'd0: begin
        unique case (idx)
          3'd0: begin
            regRdata[NUM_MOD-1:0] = modFlag;
            regRdata[6]           = runBit;
            regRdata[7]           = ovfFlag;
          end
          3'd1:    regRdata = {5'b0, clkSel, ovfIe};
          3'd2:    regRdata = cntVal[7:0];
          3'd3:    regRdata = cntVal[15:8];
          default: regRdata = '0;
        endcase
      end
      default: begin
        for (int i = 0; i < NUM_MOD; i++) begin
          if (idx == 3'(i)) begin
            if (grp == 2'd1)      regRdata = {1'b0, modeReg[i]};
            else if (grp == 2'd2) regRdata = cmpVal[i][7:0];
            else                  regRdata = cmpVal[i][15:8];
          end
        end
      end
    endcase
  end

  always_comb begin
    for (int i = 0; i < NUM_MOD; i++) intEnVec[i] = modeReg[i].intEn;
  end
  assign irq = (ovfFlag && ovfIe) || |(modFlag & intEnVec);
endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pcaStrobe_t                    strb,
  input  pcaMode_t [NUM_MOD-1:0]        modeReg,
  input  logic [NUM_MOD-1:0]            pinIn,
  output logic [NUM_MOD-1:0]            pinOut,
  output logic [CNT_W-1:0]              cntVal,
  output logic [NUM_MOD-1:0][CNT_W-1:0] cmpVal,
  output logic [NUM_MOD-1:0]            modFlag,
  output logic                          ovfFlag
);
  logic cntWr, cntStep, loWrap;

  assign cntWr   = strb.cntLoWr | strb.cntHiWr;
  assign cntStep = strb.tick & ~cntWr;
  assign loWrap  = cntStep && cntVal[7:0] == 8'hFF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (strb.cntLoWr)      cntVal[7:0]  <= strb.wdata;
      else if (strb.cntHiWr) cntVal[15:8] <= strb.wdata;
      else if (strb.tick)    cntVal       <= cntVal + 1'b1;
      if (cntStep && cntVal == '1) ovfFlag <= 1'b1;
      else if (strb.ovfClr)        ovfFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_MOD; g++) begin : gChan
    logic [SYNC_STAGES:0] pinSync;
    logic [CNT_W-1:0]     cmpR;
    logic                 flagR, togR, rise, fall, capEvt, match;

    assign rise   = pinSync[SYNC_STAGES-1] & ~pinSync[SYNC_STAGES];
    assign fall   = ~pinSync[SYNC_STAGES-1] & pinSync[SYNC_STAGES];
    assign capEvt = (modeReg[g].capPos & rise) | (modeReg[g].capNeg & fall);
    assign match  = modeReg[g].cmpEn && cntStep && cntVal == cmpR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinSync <= '0;
        cmpR    <= '0;
        flagR   <= 1'b0;
        togR    <= 1'b0;
      end else begin
        pinSync <= {pinSync[SYNC_STAGES-1:0], pinIn[g]};
        if (strb.cmpLoWr[g])      cmpR[7:0]  <= strb.wdata;
        else if (strb.cmpHiWr[g]) cmpR[15:8] <= strb.wdata;
        else if (capEvt)          cmpR       <= cntVal;
        else if (modeReg[g].pwmEn && loWrap) cmpR[7:0] <= cmpR[15:8];
        if ((match && modeReg[g].matEn) || capEvt) flagR <= 1'b1;
        else if (strb.flagClr[g])                  flagR <= 1'b0;
        if (match && modeReg[g].togEn) togR <= ~togR;
      end
    end

    assign cmpVal[g]  = cmpR;
    assign modFlag[g] = flagR;
    assign pinOut[g]  = (modeReg[g].pwmEn && modeReg[g].cmpEn) ? (cntVal[7:0] >= cmpR[7:0]) : togR;
  end
endmodule

// File: rtl/pca_array.sv
module pca_array
  import pca_pkg::*;
#(
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BYTE_W-1:0]  regWdata,
  output logic [BYTE_W-1:0]  regRdata,
  input  logic               extCount,
  input  logic [NUM_MOD-1:0] modPinIn,
  output logic [NUM_MOD-1:0] modPinOut,
  output logic               irq
);
  pcaStrobe_t                    strb;
  pcaMode_t [NUM_MOD-1:0]        modeReg;
  logic [CNT_W-1:0]              cntVal;
  logic [NUM_MOD-1:0][CNT_W-1:0] cmpVal;
  logic [NUM_MOD-1:0]            modFlag, cmpEnVec;
  logic                          ovfFlag, ovfIe;

  always_comb begin
    for (int i = 0; i < NUM_MOD; i++) cmpEnVec[i] = modeReg[i].cmpEn;
  end

  pca_ctrl #(.PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .extCount(extCount), .cntVal(cntVal), .cmpVal(cmpVal),
    .modFlag(modFlag), .ovfFlag(ovfFlag), .strb(strb), .modeReg(modeReg),
    .ovfIe(ovfIe), .irq(irq)
  );

  pca_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .modeReg(modeReg), .pinIn(modPinIn),
    .pinOut(modPinOut), .cntVal(cntVal), .cmpVal(cmpVal), .modFlag(modFlag),
    .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/pca_array_checker.sv
module pca_array_checker
  import pca_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               cntLoWr,
  input logic               cntHiWr,
  input logic [CNT_W-1:0]   cntVal,
  input logic               ovfFlag,
  input logic               ovfIe,
  input logic               irq,
  input logic [NUM_MOD-1:0] cmpLoWr,
  input logic [NUM_MOD-1:0] cmpHiWr,
  input logic [NUM_MOD-1:0] cmpEnVec
);
  logic cntWr;
  assign cntWr = cntLoWr | cntHiWr;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cntWr) |=> $stable(cntVal));

  assert_wrap_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWr && cntVal == 16'hFFFF) |=> (ovfFlag && cntVal == 16'h0000));

  assert_wrap_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(cntVal) == 16'hFFFF);

  assert_wrap_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && ovfIe) |-> irq);

  for (genvar g = 0; g < NUM_MOD; g++) begin : gChk
    assert_lo_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
      cmpLoWr[g] |=> !cmpEnVec[g]);
    assert_hi_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
      cmpHiWr[g] |=> cmpEnVec[g]);
  end
endmodule

bind pca_array pca_array_checker uChk (
  .clk(clk), .rstN(rstN), .tick(strb.tick), .cntLoWr(strb.cntLoWr),
  .cntHiWr(strb.cntHiWr), .cntVal(cntVal), .ovfFlag(ovfFlag), .ovfIe(ovfIe),
  .irq(irq), .cmpLoWr(strb.cmpLoWr), .cmpHiWr(strb.cmpHiWr), .cmpEnVec(cmpEnVec)
);

// File: tb/pca_array_test.sv
`timescale 1ns/1ps
module pca_array_test;
  localparam int PS = 6, PF = 3;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h01, A_CLO = 5'h02, A_CHI = 5'h03;
  localparam logic [4:0] A_MODE = 5'h08, A_CMPL = 5'h10, A_CMPH = 5'h18;

  logic clk = 0, rstN = 0, regWe = 0, extCount = 0;
  logic [4:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic [4:0] modPinIn = 0, modPinOut;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  pca_array #(.PRE_SLOW(PS), .PRE_FAST(PF), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .extCount(extCount), .modPinIn(modPinIn),
    .modPinOut(modPinOut), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1;
    @(posedge clk); #1 regWe = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdata;
  endtask

  task automatic rdCnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(A_CLO, lo); rd(A_CHI, hi); v = {hi, lo};
  endtask

  task automatic setCnt(input logic [15:0] v);
    wr(A_CLO, v[7:0]); wr(A_CHI, v[15:8]);
  endtask

  // run bit on, n further edges, run bit off: n+1 edges see run=1
  task automatic runFor(input int n);
    wr(A_CTRL, 8'hDF); repeat (n) @(posedge clk); wr(A_CTRL, 8'h9F);
  endtask

  task automatic extPulse();
    @(negedge clk); extCount = 1; repeat (3) @(negedge clk);
    extCount = 0; repeat (3) @(negedge clk);
  endtask

  function automatic int divTicks(input int edges, input int pre);
    return edges / pre;
  endfunction

  function automatic bit pwmLevel(input logic [7:0] cl, input logic [7:0] cmpLo);
    return cl >= cmpLo;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [7:0] v, mv, lo8;
    logic [15:0] c16, cv, prevCap, expCap;
    logic pinLvl, capt;
    int md, seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // reset state
    rd(A_CTRL, v); chk("R4 reset control", v, 8'h00);
    rdCnt(c16);   chk("R1 reset counter", c16, 0);
    chk("R10 reset irq", irq, 0);
    chk("R7 reset pins", modPinOut, 0);

    // R1: every-clock ticks, hold when stopped
    wr(A_CFG, 8'h06); setCnt(16'h1234); runFor(9);
    rdCnt(c16); chk("R1 count run", c16, 16'h1234 + 10);
    repeat (5) @(posedge clk);
    rdCnt(c16); chk("R1 hold stopped", c16, 16'h1234 + 10);

    // R2: dividers and external count
    wr(A_CFG, 8'h00); setCnt(0); runFor(29);
    rdCnt(c16); chk("R2 slow divider", c16, divTicks(30, PS));
    wr(A_CFG, 8'h02); setCnt(0); runFor(20);
    rdCnt(c16); chk("R2 fast divider", c16, divTicks(21, PF));
    wr(A_CFG, 8'h04); setCnt(0);
    extPulse(); extPulse(); repeat (4) @(posedge clk);
    rdCnt(c16); chk("R1 ext pulses while stopped", c16, 0);
    wr(A_CTRL, 8'hDF);
    for (int k = 0; k < 5; k++) extPulse();
    repeat (6) @(posedge clk); wr(A_CTRL, 8'h9F);
    rdCnt(c16); chk("R2 external count", c16, 5);

    // R3 / R10: wrap flag
    wr(A_CFG, 8'h07); setCnt(16'hFFFE); runFor(2);
    rdCnt(c16); chk("R3 wrap value", c16, 16'h0001);
    rd(A_CTRL, v); chk("R3 wrap flag", v[7], 1);
    chk("R10 wrap irq", irq, 1);
    wr(A_CTRL, 8'h9F); rd(A_CTRL, v); chk("R3 write one keeps", v[7], 1);
    wr(A_CTRL, 8'h1F); rd(A_CTRL, v); chk("R3 write zero clears", v[7], 0);
    chk("R10 irq after clear", irq, 0);
    wr(A_CFG, 8'h06);

    // R9: compare enable follows byte writes
    wr(A_MODE + 0, 8'h49); rd(A_MODE + 0, v); chk("R9 mode readback", v, 8'h49);
    wr(A_CMPL + 0, 8'h10); rd(A_MODE + 0, v); chk("R9 low write clears", v, 8'h09);
    wr(A_CMPH + 0, 8'h00); rd(A_MODE + 0, v); chk("R9 high write sets", v, 8'h49);

    // R6 / R10: software timer match on channel 0
    setCnt(16'h000C); runFor(7);
    rd(A_CTRL, v); chk("R6 match flag ch0", v[4:0], 5'h01);
    chk("R10 channel irq", irq, 1);
    wr(A_CTRL, 8'h00); chk("R10 irq cleared", irq, 0);
    // no compare enable: no match on channel 1
    wr(A_CMPL + 1, 8'h30); wr(A_CMPH + 1, 8'h00); wr(A_MODE + 1, 8'h09);
    setCnt(16'h002C); runFor(7);
    rd(A_CTRL, v); chk("R6 disabled compare", v[4:0], 5'h00);

    // R7 / R4: toggle output on channel 2, no interrupt enable
    wr(A_CMPL + 2, 8'h50); wr(A_CMPH + 2, 8'h00); wr(A_MODE + 2, 8'h4C);
    setCnt(16'h004C); runFor(7);
    @(negedge clk); chk("R7 toggle high", modPinOut[2], 1);
    rd(A_CTRL, v); chk("R4 flag position ch2", v[4:0], 5'h04);
    chk("R10 flag without enable", irq, 0);
    setCnt(16'h004C); runFor(7);
    @(negedge clk); chk("R7 toggle low", modPinOut[2], 0);

    // R5: random capture on channel 3 (counter stopped)
    wr(A_CMPL + 3, 8'h00); wr(A_CMPH + 3, 8'h00);
    prevCap = 0; pinLvl = 0;
    for (int k = 0; k < 10; k++) begin
      md = $urandom % 3;
      mv = (md == 0) ? 8'h20 : (md == 1) ? 8'h10 : 8'h30;
      cv = 16'($urandom);
      wr(A_CTRL, 8'h00); wr(A_MODE + 3, mv); setCnt(cv);
      @(negedge clk); pinLvl = ~pinLvl; modPinIn[3] = pinLvl;
      repeat (5) @(posedge clk);
      capt = pinLvl ? mv[5] : mv[4];
      expCap = capt ? cv : prevCap;
      rd(A_CMPL + 3, lo8); rd(A_CMPH + 3, v);
      chk("R5 capture value", {v, lo8}, expCap);
      rd(A_CTRL, v); chk("R5 capture flag", v[3], capt);
      prevCap = expCap;
    end

    // R8: pulse width on channel 4
    wr(A_CTRL, 8'h00);
    wr(A_CMPL + 4, 8'h80); wr(A_CMPH + 4, 8'h40); wr(A_MODE + 4, 8'h42);
    wr(A_CLO, 8'h80); @(negedge clk); chk("R8 equal boundary", modPinOut[4], 1);
    wr(A_CLO, 8'h7F); @(negedge clk); chk("R8 just below", modPinOut[4], 0);
    for (int k = 0; k < 6; k++) begin
      lo8 = 8'($urandom);
      wr(A_CLO, lo8); @(negedge clk);
      chk("R8 random level", modPinOut[4], pwmLevel(lo8, 8'h80));
    end
    setCnt(16'h00FE); runFor(1);
    rdCnt(c16); chk("R8 reload count", c16, 16'h0100);
    rd(A_CMPL + 4, v); chk("R8 reload low byte", v, 8'h40);
    chk("R8 level after reload", modPinOut[4], 0);
    wr(A_CLO, 8'h40); @(negedge clk); chk("R8 new threshold", modPinOut[4], 1);

    done = 1;
    finishRun();
  end
endmodule